// File: doc/BRIEF.md
# Four-Entry Master Byte Buffer

This block is a small byte queue that sits between a processor-facing register port and an I2C master transfer engine. Software pushes bytes one at a time through a write strobe and pops them through a read strobe. The byte at the head is always visible on the read-data output. The transfer engine can replace the contents and occupancy in a single cycle after a receive transfer. A flush input empties the queue.

Occupancy is held as a count from 0 (empty) to 4 (full). Two status flags report "holding data" and "full". These flags are state bits in their own right and are not decoded from the count. The processor path only moves them on the edge transitions: the first byte in or out, and the fourth byte in or out. The engine load can only set them. As a result, a full flag set before an engine load of fewer bytes stays set.

Top module: `xbb_buffer`

## Requirements
- R1: After reset the occupancy count is 0, both flags are 0, and `cpu_rdata` reads 0xFF.
- R2: A write strobe on a buffer holding fewer than 4 bytes stores `cpu_wdata` behind the last held byte and raises the count by one. Bytes come out in the order they were written.
- R3: A write strobe alone while the count is 4 is dropped. The count, the flags and the stored bytes do not change.
- R4: While the count is nonzero, `cpu_rdata` shows the oldest byte. A read strobe removes that byte, moves the rest one place toward the head, and lowers the count by one.
- R5: While the count is 0, `cpu_rdata` is 0xFF. A read strobe alone changes neither the count nor the flags.
- R6: Through the processor path, `has_data` is set only by a write that takes the count from 0 to 1 and cleared only by a read that takes it from 1 to 0. `full` is set only by a write that takes the count from 3 to 4 and cleared only by a read at count 4.
- R7: A flush sets the count to 0 and clears both flags. The read and write strobes in that cycle are ignored.
- R8: An engine load with count N (0 to 4; larger values are treated as 4) puts byte i of `eng_data` (bits 8i+7 down to 8i) at position i for every i below N and sets the count to N. It sets `has_data` if N is at least 1 and `full` if N is 4. Otherwise it leaves each flag as it was.
- R9: An engine load takes priority over a flush and over both processor strobes in the same cycle.
- R10: When both strobes are active in one cycle, the read is applied first and then the write is applied to the result. The flags follow R6 for each step in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Push strobe |
| cpu_wdata | input | 8 | Byte to push |
| cpu_rd | input | 1 | Pop strobe |
| cpu_rdata | output | 8 | Head byte, or 0xFF when empty |
| flush | input | 1 | Empty the buffer |
| eng_load | input | 1 | Engine bulk-load strobe |
| eng_count | input | 3 | Number of bytes loaded by the engine |
| eng_data | input | 32 | Bytes loaded by the engine, position i in bits 8i+7:8i |
| occupancy | output | 3 | Bytes held, 0 to 4 |
| has_data | output | 1 | Holding-data flag |
| full | output | 1 | Full flag |

## Verification
The bench starts from every occupancy from 0 to 4 and applies every combination of the two strobes. It then drains the buffer and compares each byte against an arithmetic model. A design that pops from an empty buffer would wrap the count, and one that accepts a fifth byte would overwrite the tail; both show up as count or data mismatches. Engine loads of every size are applied over every starting occupancy, so a design that derives the flags from the count, or clears them on a short load, disagrees with the sticky `full` flag expected after loading two bytes into a full buffer. The bench also holds flush or load together with the strobes, which exposes a wrong priority order.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  // Limit an engine-supplied byte count to the buffer depth.
  function automatic int clamp_load(input int n, input int depth);
    return (n > depth) ? depth : n;
  endfunction

  // Occupancy left after an optional pop.
  function automatic int after_pop(input int cnt, input bit pop);
    return (pop && cnt > 0) ? cnt - 1 : cnt;
  endfunction
endpackage

// File: rtl/xbb_tracker.sv
module xbb_tracker #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          flush,
  input  logic          eng_load,
  input  logic [CW-1:0] eng_count,
  output logic [CW-1:0] count,
  output logic          has_data,
  output logic          full,
  output logic          pop_fire,
  output logic          push_fire,
  output logic [IW-1:0] push_slot,
  output logic [CW-1:0] load_n
);
  import xbb_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          cpu_ok;
  logic [CW-1:0] mid_cnt;
  logic [CW-1:0] count_n;
  logic          has_n, full_n;

  always_comb begin
    cpu_ok    = !eng_load && !flush;
    pop_fire  = cpu_ok && cpu_rd && (count != '0);
    mid_cnt   = CW'(after_pop(int'(count), pop_fire));
    push_fire = cpu_ok && cpu_wr && (mid_cnt != FULL_CNT);
    push_slot = mid_cnt[IW-1:0];
    load_n    = CW'(clamp_load(int'(eng_count), DEPTH));
  end

  always_comb begin
    count_n = count;
    has_n   = has_data;
    full_n  = full;
    if (eng_load) begin
      count_n = load_n;
      if (load_n != '0)      has_n  = 1'b1;
      if (load_n == FULL_CNT) full_n = 1'b1;
    end else if (flush) begin
      count_n = '0;
      has_n   = 1'b0;
      full_n  = 1'b0;
    end else begin
      if (pop_fire && count == CW'(1))  has_n  = 1'b0;
      if (pop_fire && count == FULL_CNT) full_n = 1'b0;
      if (push_fire && mid_cnt == '0)   has_n  = 1'b1;
      if (push_fire && mid_cnt == FULL_CNT - CW'(1)) full_n = 1'b1;
      count_n = mid_cnt + CW'(push_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else begin
      count    <= count_n;
      has_data <= has_n;
      full     <= full_n;
    end
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && cpu_wr && !cpu_rd && !flush && !eng_load)
      |=> (count == FULL_CNT && full == $past(full) && has_data == $past(has_data)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && cpu_rd && !cpu_wr && !flush && !eng_load)
      |=> (count == '0 && $stable(has_data) && $stable(full)));

  // R6
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past((push_fire && push_slot == IW'(DEPTH - 1)) ||
                          (eng_load && load_n == FULL_CNT)));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !eng_load) |=> (count == '0 && !has_data && !full));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |=> (count == $past(load_n)));
endmodule

// File: rtl/xbb_store.sv
module xbb_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pop_fire,
  input  logic                   push_fire,
  input  logic [IW-1:0]          push_slot,
  input  logic [WIDTH-1:0]       wdata,
  input  logic                   flush,
  input  logic                   eng_load,
  input  logic [CW-1:0]          load_n,
  input  logic [DEPTH*WIDTH-1:0] eng_data,
  output logic [WIDTH-1:0]       head
);
  logic [DEPTH-1:0][WIDTH-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] nxt;

    if (g < DEPTH - 1) begin : g_mid
      assign shifted = pop_fire ? mem[g+1] : mem[g];
    end else begin : g_last
      assign shifted = mem[g];
    end

    always_comb begin
      nxt = mem[g];
      if (eng_load) begin
        if (CW'(g) < load_n) nxt = eng_data[g*WIDTH +: WIDTH];
      end else if (flush) begin
        nxt = '0;
      end else if (push_fire && push_slot == IW'(g)) begin
        nxt = wdata;
      end else begin
        nxt = shifted;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else        mem[g] <= nxt;
    end
  end

  assign head = mem[0];
endmodule

// File: rtl/xbb_buffer.sv
module xbb_buffer #(
  parameter int              DEPTH     = 4,
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] EMPTY_VAL = '1,
  localparam int             CW        = $clog2(DEPTH + 1),
  localparam int             IW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_wr,
  input  logic [WIDTH-1:0]       cpu_wdata,
  input  logic                   cpu_rd,
  output logic [WIDTH-1:0]       cpu_rdata,
  input  logic                   flush,
  input  logic                   eng_load,
  input  logic [CW-1:0]          eng_count,
  input  logic [DEPTH*WIDTH-1:0] eng_data,
  output logic [CW-1:0]          occupancy,
  output logic                   has_data,
  output logic                   full
);
  logic          pop_fire, push_fire;
  logic [IW-1:0] push_slot;
  logic [CW-1:0] load_n;
  logic [WIDTH-1:0] head;

  xbb_tracker #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_track (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .flush(flush), .eng_load(eng_load), .eng_count(eng_count),
    .count(occupancy), .has_data(has_data), .full(full),
    .pop_fire(pop_fire), .push_fire(push_fire), .push_slot(push_slot),
    .load_n(load_n)
  );

  xbb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .pop_fire(pop_fire), .push_fire(push_fire),
    .push_slot(push_slot), .wdata(cpu_wdata), .flush(flush),
    .eng_load(eng_load), .load_n(load_n), .eng_data(eng_data), .head(head)
  );

  assign cpu_rdata = (occupancy == '0) ? EMPTY_VAL : head;

  // R5
  flush_reads_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !eng_load) |=> (cpu_rdata == EMPTY_VAL));

  // R4
  pop_moves_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire && occupancy > CW'(1)) |=> (occupancy == $past(occupancy) - CW'(1)));
endmodule

// File: tb/tb_xbb_buffer.sv
`timescale 1ns/1ps
module tb_xbb_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, flush = 1'b0, eng_load = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [2:0]  eng_count = '0;
  logic [31:0] eng_data = '0;
  logic [7:0]  cpu_rdata;
  logic [2:0]  occupancy;
  logic        has_data, full;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_q[4];
  int m_cnt = 0;
  bit m_has = 0, m_full = 0;

  always #2.5 clk = ~clk;

  xbb_buffer dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .flush(flush),
    .eng_load(eng_load), .eng_count(eng_count), .eng_data(eng_data),
    .occupancy(occupancy), .has_data(has_data), .full(full)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Model of the requirements, applied once per cycle.
  task automatic model_step(input bit rd, input bit wr, input int wd,
                            input bit fl, input bit ld, input int n, input logic [31:0] d);
    if (ld) begin
      int k = (n > 4) ? 4 : n;
      for (int i = 0; i < k; i++) m_q[i] = int'(d[8*i +: 8]);
      m_cnt = k;
      if (k >= 1) m_has = 1;
      if (k == 4) m_full = 1;
    end else if (fl) begin
      m_cnt = 0; m_has = 0; m_full = 0;
    end else begin
      if (rd && m_cnt > 0) begin
        if (m_cnt == 1) m_has = 0;
        if (m_cnt == 4) m_full = 0;
        for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
        m_cnt--;
      end
      if (wr && m_cnt < 4) begin
        if (m_cnt == 0) m_has = 1;
        if (m_cnt == 3) m_full = 1;
        m_q[m_cnt] = wd;
        m_cnt++;
      end
    end
  endtask

  // One cycle: drive at negedge, check head, clock, check registered state.
  task automatic cyc(input string tag, input bit rd, input bit wr, input int wd,
                     input bit fl, input bit ld, input int n, input logic [31:0] d);
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd[7:0]; flush = fl;
    eng_load = ld; eng_count = n[2:0]; eng_data = d;
    #1;
    if (m_cnt == 0) check("R5", "rdata", int'(cpu_rdata), 8'hFF);
    else            check("R4", "rdata", int'(cpu_rdata), m_q[0]);
    @(posedge clk);
    model_step(rd, wr, wd, fl, ld, n, d);
    @(negedge clk);
    check(tag, "occupancy", int'(occupancy), m_cnt);
    check(ld ? "R8" : "R6", "has_data", int'(has_data), int'(m_has));
    check(ld ? "R8" : "R6", "full", int'(full), int'(m_full));
    cpu_rd = 0; cpu_wr = 0; flush = 0; eng_load = 0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 5; i++) cyc(tag, 1, 0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "occupancy", int'(occupancy), 0);
    check("R1", "has_data", int'(has_data), 0);
    check("R1", "full", int'(full), 0);
    check("R1", "rdata", int'(cpu_rdata), 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // Every starting occupancy against every strobe pair (R2 R3 R4 R5 R10)
    for (int s = 0; s <= 4; s++) begin
      for (int op = 0; op < 4; op++) begin
        bit rd = op[0];
        bit wr = op[1];
        string tag;
        cyc("R7", 0, 0, 0, 1, 0, 0, '0);
        for (int i = 0; i < s; i++) cyc("R2", 0, 1, s*16 + i + 1, 0, 0, 0, '0);
        if (rd && wr)            tag = "R10";
        else if (wr && s == 4)   tag = "R3";
        else if (wr)             tag = "R2";
        else if (rd && s == 0)   tag = "R5";
        else                     tag = "R4";
        cyc(tag, rd, wr, 8'hA0 + s*4 + op, 0, 0, 0, '0);
        drain("R4");
      end
    end

    // Flush held with both strobes: strobes ignored (R7)
    for (int i = 0; i < 3; i++) cyc("R2", 0, 1, 8'h30 + i, 0, 0, 0, '0);
    cyc("R7", 1, 1, 8'h55, 1, 0, 0, '0);
    cyc("R7", 0, 1, 8'h66, 0, 0, 0, '0);
    drain("R7");

    // Engine loads of every size over every starting occupancy (R8)
    for (int s = 0; s <= 4; s++) begin
      for (int n = 0; n <= 5; n++) begin
        logic [31:0] d = 32'h0 + (n * 32'h11111111) ^ (s * 32'h01020408) ^ 32'hC3A5_5A3C;
        cyc("R7", 0, 0, 0, 1, 0, 0, '0);
        for (int i = 0; i < s; i++) cyc("R2", 0, 1, 8'h70 + i, 0, 0, 0, '0);
        cyc("R8", 0, 0, 0, 0, 1, n, d);
        drain("R8");
      end
    end

    // Load wins over flush and strobes in the same cycle (R9)
    cyc("R7", 0, 0, 0, 1, 0, 0, '0);
    cyc("R2", 0, 1, 8'h11, 0, 0, 0, '0);
    cyc("R9", 1, 1, 8'h99, 1, 1, 3, 32'h44332211);
    drain("R9");
    cyc("R9", 1, 0, 0, 1, 1, 4, 32'hDDCCBBAA);
    cyc("R2", 0, 1, 8'hEE, 0, 0, 0, '0);
    drain("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule